// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Controller

This block keeps a fast-page DRAM array alive by issuing CAS-before-RAS refresh cycles. The DRAM advances its own row counter on each such cycle, so the block produces no address. It drives the row strobe, every column-strobe lane and the write strobe while it owns the memory pins. Ownership is agreed with the access sequencer through a plain request/grant pair. `ref_req` rises when work is pending and stays high until the whole burst has finished. The sequencer answers with `ref_gnt` and must hold it high for as long as `ref_req` is high. While the block does not own the pins, its strobe outputs rest high. The sequencer selects between its own strobes and these outputs using the grant.

After reset the block waits for a power-up pause. It then runs a fixed number of initialization cycles, and only after those does it raise `ready`, which permits normal accesses. In steady state an interval timer schedules one refresh per interval. If the grant is held off, the missed intervals are counted up to a limit and then issued back to back under one request. If no refresh has completed for an idle limit, the block drops `ready` and repeats the initialization burst before raising it again. All times are parameters in clock cycles.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `ref_req` and `ready` are 0 and `ram_ras_n`, every `ram_cas_n` lane and `ram_we_n` are 1.
- R2: `ref_req` stays low for at least PAUSE_CYCLES clocks after reset is released and rises no later than PAUSE_CYCLES+2 clocks after release.
- R3: `ready` rises only when the request that carries exactly INIT_CYCLES refresh cycles ends. It rises in the same clock that `ref_req` falls.
- R4: `ram_ras_n` falls only while both `ref_req` and `ref_gnt` are high. A request with the grant held low produces no strobe activity.
- R5: All `ram_cas_n` lanes carry the same value. They are low for at least CAS_SETUP clocks before `ram_ras_n` falls and stay low for at least CAS_HOLD clocks after it falls.
- R6: `ram_we_n` is 1 on every clock, so each cycle is taken as a refresh and never as a write.
- R7: `ram_ras_n` stays low for at least RAS_LOW clocks per cycle. It stays high for at least PRECHARGE clocks before every fall.
- R8: In steady state with an immediate grant, each request carries exactly one cycle. Consecutive requests rise exactly TICK_CYCLES clocks apart.
- R9: If the grant is delayed across j further interval boundaries after a request, the burst issued under that request has min(MAX_OWED, 1+j) cycles.
- R10: If no refresh cycle completes for IDLE_LIMIT clocks after `ready` has been set, `ready` falls while `ref_req` is high. The next burst has INIT_CYCLES cycles, and `ready` rises again when that burst ends.
- R11: `ref_req` falls only when `ram_ras_n` and every `ram_cas_n` lane are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Sequencer hands the memory pins to this block |
| ref_req | output | 1 | Refresh work pending; held until the burst ends |
| ready | output | 1 | Initialization done; normal accesses allowed |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | CAS_LANES | Column strobes, one per lane, active low |
| ram_we_n | output | 1 | Write strobe, held high |

## Verification
The assertions check the strobe ordering and the minimum widths on every clock: column before row, the column hold after the row falls, row low time, precharge, and that strobe activity happens only under request and grant. On every clock they also check that `ready` changes only at the edges of a request. Only the bench scenarios can show the counts over time. These are the power-up pause length, the exact number of cycles in an initialization burst, the steady interval spacing, the saturating tally of deferred refreshes swept across grant delays, and the idle-triggered re-initialization.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    CTL_PAUSE,
    CTL_IDLE,
    CTL_WAIT,
    CTL_RUN,
    CTL_NEXT
  } ctl_state_t;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_SETUP,
    PH_LOW,
    PH_PRE
  } phase_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rfsh_span_timer.sv
module rfsh_span_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic reached
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (en && (cnt_q != W'(LIMIT))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign reached = (cnt_q == W'(LIMIT));

endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int TICK_CYCLES = 3120,
  parameter int MAX_OWED    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dec,
  input  logic clr,
  output logic pending
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [TW-1:0] tick_q;
  logic [OW-1:0] owed_q;
  logic          tick;

  assign tick = en && (tick_q == TW'(TICK_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (en) begin
      tick_q <= tick ? '0 : tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      owed_q <= '0;
    end else begin
      unique case ({tick, dec})
        2'b10:   if (owed_q != OW'(MAX_OWED)) owed_q <= owed_q + 1'b1;
        2'b01:   if (owed_q != '0) owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  assign pending = (owed_q != '0);

endmodule

// File: rtl/rfsh_cbr_cycle.sv
module rfsh_cbr_cycle
  import rfsh_pkg::*;
#(
  parameter int CAS_SETUP = 2,
  parameter int CAS_HOLD  = 2,
  parameter int RAS_LOW   = 12,
  parameter int PRECHARGE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ras_n,
  output logic cas_n,
  output logic done
);
  localparam int MAXP = max_of4(CAS_SETUP, CAS_HOLD, RAS_LOW, PRECHARGE);
  localparam int CW   = $clog2(MAXP + 1);

  phase_t        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_OFF;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_OFF: begin
          cnt_q <= '0;
          if (start) ph_q <= PH_SETUP;
        end
        PH_SETUP: begin
          if (cnt_q == CW'(CAS_SETUP - 1)) begin
            ph_q  <= PH_LOW;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt_q == CW'(RAS_LOW - 1)) begin
            ph_q  <= PH_PRE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == CW'(PRECHARGE - 1)) begin
            ph_q  <= PH_OFF;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign ras_n = (ph_q != PH_LOW);
  assign cas_n = !((ph_q == PH_SETUP) || ((ph_q == PH_LOW) && (cnt_q < CW'(CAS_HOLD))));
  assign done  = (ph_q == PH_PRE) && (cnt_q == CW'(PRECHARGE - 1));

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import rfsh_pkg::*;
#(
  parameter int CAS_LANES    = 4,
  parameter int TICK_CYCLES  = 3120,
  parameter int PAUSE_CYCLES = 100000,
  parameter int INIT_CYCLES  = 8,
  parameter int IDLE_LIMIT   = 12800000,
  parameter int MAX_OWED     = 8,
  parameter int CAS_SETUP    = 2,
  parameter int CAS_HOLD     = 2,
  parameter int RAS_LOW      = 12,
  parameter int PRECHARGE    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_gnt,
  output logic                 ref_req,
  output logic                 ready,
  output logic                 ram_ras_n,
  output logic [CAS_LANES-1:0] ram_cas_n,
  output logic                 ram_we_n
);
  localparam int LW = $clog2(INIT_CYCLES + 1);

  ctl_state_t    state_q, state_d;
  logic          init_q;
  logic [LW-1:0] left_q;
  logic          ready_q;
  logic          up_q;

  logic pause_done, idle_hit, pending;
  logic cyc_start, cyc_done, cyc_ras_n, cyc_cas_n;
  logic more, finish, trigger;

  rfsh_span_timer #(.LIMIT(PAUSE_CYCLES)) u_pause (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (state_q == CTL_PAUSE),
    .clr     (1'b0),
    .reached (pause_done)
  );

  rfsh_span_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (up_q && !init_q),
    .clr     (cyc_done),
    .reached (idle_hit)
  );

  rfsh_interval #(
    .TICK_CYCLES (TICK_CYCLES),
    .MAX_OWED    (MAX_OWED)
  ) u_interval (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (up_q),
    .dec     (cyc_done && !init_q),
    .clr     (finish),
    .pending (pending)
  );

  rfsh_cbr_cycle #(
    .CAS_SETUP (CAS_SETUP),
    .CAS_HOLD  (CAS_HOLD),
    .RAS_LOW   (RAS_LOW),
    .PRECHARGE (PRECHARGE)
  ) u_cycle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cyc_start),
    .ras_n (cyc_ras_n),
    .cas_n (cyc_cas_n),
    .done  (cyc_done)
  );

  assign trigger   = up_q && !init_q && idle_hit &&
                     ((state_q == CTL_IDLE) || (state_q == CTL_WAIT));
  assign more      = init_q ? (left_q != '0) : pending;
  assign finish    = (state_q == CTL_NEXT) && init_q && (left_q == '0);
  assign cyc_start = ((state_q == CTL_WAIT) && ref_gnt) ||
                     ((state_q == CTL_NEXT) && more);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CTL_PAUSE: if (pause_done) state_d = CTL_WAIT;
      CTL_IDLE:  if (trigger || pending) state_d = CTL_WAIT;
      CTL_WAIT:  if (ref_gnt) state_d = CTL_RUN;
      CTL_RUN:   if (cyc_done) state_d = CTL_NEXT;
      default:   state_d = more ? CTL_RUN : CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CTL_PAUSE;
      init_q  <= 1'b1;
      left_q  <= LW'(INIT_CYCLES);
      ready_q <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (trigger) begin
        init_q  <= 1'b1;
        left_q  <= LW'(INIT_CYCLES);
        ready_q <= 1'b0;
      end else if (finish) begin
        init_q  <= 1'b0;
        ready_q <= 1'b1;
        up_q    <= 1'b1;
      end else if (cyc_done && init_q) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign ref_req   = (state_q == CTL_WAIT) || (state_q == CTL_RUN) || (state_q == CTL_NEXT);
  assign ready     = ready_q;
  assign ram_ras_n = cyc_ras_n;
  assign ram_we_n  = 1'b1;

  for (genvar g = 0; g < CAS_LANES; g++) begin : g_lane
    assign ram_cas_n[g] = cyc_cas_n;
  end

endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
  parameter int CAS_LANES = 4,
  parameter int RAS_LOW   = 12,
  parameter int PRECHARGE = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ref_gnt,
  input logic                 ref_req,
  input logic                 ready,
  input logic                 ram_ras_n,
  input logic [CAS_LANES-1:0] ram_cas_n,
  input logic                 ram_we_n
);
  logic [15:0] low_run, high_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= 16'hffff;
    end else begin
      if (!ram_ras_n) begin
        low_run  <= (low_run == 16'hffff) ? low_run : low_run + 1'b1;
        high_run <= '0;
      end else begin
        low_run  <= '0;
        high_run <= (high_run == 16'hffff) ? high_run : high_run + 1'b1;
      end
    end
  end

  // R4
  fall_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_ras_n) |-> (ref_req && ref_gnt));

  // R5
  cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_ras_n) |-> ((ram_cas_n == '0) && $past(ram_cas_n == '0)));

  // R5
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_ras_n) |=> (ram_cas_n == '0));

  // R7
  ras_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_ras_n) |-> (low_run >= 16'(RAS_LOW)));

  // R7
  precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_ras_n) |-> (high_run >= 16'(PRECHARGE)));

  // R11
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_req) |-> (ram_ras_n && (ram_cas_n == '1)));

  // R3
  ready_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (!ref_req && $past(ref_req)));

  // R10
  ready_drop_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> ref_req);

endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(
  .CAS_LANES (CAS_LANES),
  .RAS_LOW   (RAS_LOW),
  .PRECHARGE (PRECHARGE)
) u_chk (.*);

// File: tb/test_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module test_dram_refresh_ctrl;
  localparam int LANES = 4;
  localparam int TICK  = 80;
  localparam int PAUSE = 20;
  localparam int INIT  = 8;
  localparam int IDLE  = 600;
  localparam int OWED  = 3;
  localparam int CSR   = 2;
  localparam int CHR   = 2;
  localparam int RASL  = 4;
  localparam int PRE   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic auto_gnt = 1'b0;
  logic man_gnt = 1'b0;
  logic req, ready, ras_n, we_n;
  logic [LANES-1:0] cas_n;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  dram_refresh_ctrl #(
    .CAS_LANES(LANES), .TICK_CYCLES(TICK), .PAUSE_CYCLES(PAUSE),
    .INIT_CYCLES(INIT), .IDLE_LIMIT(IDLE), .MAX_OWED(OWED),
    .CAS_SETUP(CSR), .CAS_HOLD(CHR), .RAS_LOW(RASL), .PRECHARGE(PRE)
  ) i_dram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req), .ready(ready),
    .ram_ras_n(ras_n), .ram_cas_n(cas_n), .ram_we_n(we_n)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;
  always @(negedge clk) gnt <= auto_gnt ? req : man_gnt;

  // Monitor state, sampled at the falling edge
  logic s_ready = 1'b0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_req = 1'b0, p_ready = 1'b0;
  int cas_low_run = 0, ras_low_run = 0, ras_high_run = 1000;
  int burst_cnt = 0, last_burst = 0, bursts_done = 0;
  int rise_cnt = 0, prev_rise = 0, last_gap = 0, first_rise = -1;
  int falls_since = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic cas_lo, cas_hi;
      cas_lo = (cas_n == '0);
      cas_hi = (cas_n == '1);
      s_ready <= ready;
      if (!cas_lo && !cas_hi) check(1'b0, "R5 lanes equal", int'(cas_n), 0);
      if (!we_n) check(1'b0, "R6 we_n high", 0, 1);
      if (p_ras && !ras_n) begin
        check(cas_lo && cas_low_run >= CSR, "R5 cas setup", cas_low_run, CSR);
        check(ras_high_run >= PRE, "R7 precharge", ras_high_run, PRE);
        check(req && gnt, "R4 grant held", int'(req && gnt), 1);
        check(we_n == 1'b1, "R6 we_n at ras fall", int'(we_n), 1);
        burst_cnt++;
        falls_since++;
      end
      if (!p_cas && cas_hi && !ras_n)
        check(ras_low_run >= CHR, "R5 cas hold", ras_low_run, CHR);
      if (!p_ras && ras_n)
        check(ras_low_run >= RASL, "R7 ras low", ras_low_run, RASL);
      if (!p_req && req) begin
        rise_cnt++;
        if (first_rise < 0) first_rise = cyc;
        last_gap = cyc - prev_rise;
        prev_rise = cyc;
        burst_cnt = 0;
      end
      if (p_req && !req) begin
        check(ras_n && cas_hi, "R11 idle at release", int'(ras_n && cas_hi), 1);
        last_burst = burst_cnt;
        bursts_done++;
      end
      if (!p_ready && ready) begin
        check(falls_since == INIT, "R3 cycles before ready", falls_since, INIT);
        check(p_req && !req, "R3 ready at release", int'(p_req && !req), 1);
      end
      if (p_ready && !ready) begin
        falls_since = 0;
        check(req == 1'b1, "R10 ready drops under request", int'(req), 1);
      end
      cas_low_run  = cas_lo ? cas_low_run + 1 : 0;
      ras_low_run  = !ras_n ? ras_low_run + 1 : 0;
      ras_high_run = ras_n ? ras_high_run + 1 : 0;
      p_ras = ras_n; p_cas = cas_hi; p_req = req; p_ready = ready;
    end
  end

  task automatic wait_burst();
    int n0 = bursts_done;
    while (bursts_done == n0) @(posedge clk);
  endtask

  task automatic wait_rise();
    int n0 = rise_cnt;
    while (rise_cnt == n0) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(req == 1'b0 && ready == 1'b0, "R1 req/ready in reset", int'({req, ready}), 0);
    check(ras_n && we_n && cas_n == '1, "R1 strobes in reset", int'(cas_n), (1 << LANES) - 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(req == 1'b0 && ready == 1'b0 && ras_n, "R1 first cycle", int'({req, ready, ras_n}), 1);

    // R2: power-up pause, grant held low
    wait_rise();
    check(first_rise >= PAUSE && first_rise <= PAUSE + 2, "R2 pause length", first_rise, PAUSE + 1);
    repeat (15) @(posedge clk);
    check(burst_cnt == 0, "R4 no strobes without grant", burst_cnt, 0);
    check(s_ready == 1'b0, "R3 not ready before init", int'(s_ready), 0);

    // R3: initialization burst
    man_gnt = 1'b1;
    wait_burst();
    man_gnt = 1'b0;
    check(last_burst == INIT, "R3 init burst length", last_burst, INIT);
    @(posedge clk);
    check(s_ready == 1'b1, "R3 ready after init", int'(s_ready), 1);

    // R8: steady refresh with immediate grant
    auto_gnt = 1'b1;
    wait_burst();
    for (int k = 0; k < 5; k++) begin
      wait_burst();
      check(last_burst == 1, "R8 one cycle per request", last_burst, 1);
      check(last_gap == TICK, "R8 request spacing", last_gap, TICK);
    end
    auto_gnt = 1'b0;

    // R9: sweep of grant delays across interval boundaries
    for (int j = 0; j <= 4; j++) begin
      int exp;
      exp = (1 + j < OWED) ? 1 + j : OWED;
      wait_rise();
      repeat (j * TICK + 10) @(posedge clk);
      check(burst_cnt == 0, "R4 held off while waiting", burst_cnt, 0);
      man_gnt = 1'b1;
      wait_burst();
      man_gnt = 1'b0;
      check(last_burst == exp, "R9 deferred burst length", last_burst, exp);
      check(s_ready == 1'b1, "R10 ready kept below idle limit", int'(s_ready), 1);
    end

    // R10: idle recovery
    wait_rise();
    repeat (IDLE + 2 * TICK) @(posedge clk);
    check(s_ready == 1'b0, "R10 ready dropped after idle", int'(s_ready), 0);
    man_gnt = 1'b1;
    wait_burst();
    man_gnt = 1'b0;
    check(last_burst == INIT, "R10 recovery burst length", last_burst, INIT);
    @(posedge clk);
    check(s_ready == 1'b1, "R10 ready restored", int'(s_ready), 1);

    // R8: back to normal service
    auto_gnt = 1'b1;
    wait_burst();
    check(last_burst == 1, "R8 single cycle after recovery", last_burst, 1);
    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule